// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block chooses which physical frame to give up when memory is full. It keeps two bits for each frame: an occupancy bit that says whether the frame holds a page, and a reference bit that says whether the page was used recently. A hand pointer moves around the frames in a ring. When an eviction is requested, the hand inspects one frame per clock. A frame with a set reference bit gets a second chance: its bit is cleared and the hand moves on. The first frame that is empty, or occupied with a clear reference bit, becomes the victim.

Three kinds of traffic drive the block. The access port marks a frame as recently used. The fill port marks a frame as newly loaded. A one-cycle evict request starts a search. The search ends with a one-cycle victim strobe that carries the frame index and the number of frames inspected. When a victim is chosen, the block marks that frame empty and parks the hand one frame past it. A page refilled into that frame therefore sits behind the hand and is the last frame the next sweep reaches. Writing pages back, updating page tables and raising faults are the job of the surrounding logic.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every frame is empty with a clear reference bit, the hand points at frame 0 and `victim_valid` is low. The first search therefore picks frame 0 after inspecting 1 frame.
- R2: A search starts at the frame under the hand and inspects one frame per clock. `victim_valid` goes high exactly P rising edges after the edge that samples `evict_req`, where P is the number of frames inspected.
- R3: An occupied frame with a clear reference bit, when inspected, is chosen as the victim.
- R4: An occupied frame with a set reference bit, when inspected, has its reference bit cleared and is not chosen. The hand then moves to the next frame.
- R5: An empty frame, when inspected, is chosen at once, whatever its reference bit.
- R6: `victim_probes` lies between 1 and NUM_FRAMES+1. When every frame is occupied with its reference bit set, the victim is the frame where the hand started and `victim_probes` equals NUM_FRAMES+1.
- R7: When a victim is reported, the hand points one frame past it, wrapping from the last frame to frame 0, and the victim frame is marked empty.
- R8: A fill makes the named frame occupied with its reference bit set, and it does not move the hand.
- R9: An access sets the reference bit of the named frame.
- R10: If an access and a sweep clear target the same frame in the same cycle, the reference bit ends up set.
- R11: `victim_valid` is high for exactly one cycle per search. An `evict_req` that arrives while a search is in progress is ignored.
- R12: `victim_probes`, which is valid with `victim_valid`, equals the number of frames the search inspected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Access strobe: set reference bit of `acc_idx` |
| acc_idx | input | 3 | Frame that was accessed |
| fill_valid | input | 1 | Fill strobe: frame `fill_idx` newly loaded |
| fill_idx | input | 3 | Frame that was loaded |
| evict_req | input | 1 | One-cycle request to start a victim search |
| victim_valid | output | 1 | One-cycle strobe: search finished |
| victim_idx | output | 3 | Chosen frame, valid with `victim_valid` |
| victim_probes | output | 4 | Frames inspected by the search, valid with `victim_valid` |

## Verification
Two operations can hit the same frame's reference bit in one cycle: an access on the access port and the sweep clearing that bit as the hand passes. The bench forces this case. It fills every frame, starts a search from frame 0 and raises an access to frame 3 in exactly the cycle the hand inspects frame 3. After the search it refills frame 0, touches frames 1 and 2, and searches again. If the access won, frame 3 is spared and frame 4 is chosen after four inspections. If the clear had won, frame 3 would be chosen after three. Random traffic then mixes accesses, fills and searches, and a bench model predicts each victim.

// File: rtl/cvs_pkg.sv
// Shared types for the clock victim selector.
// Assumes: nothing beyond IEEE 1800-2017.
package cvs_pkg;

    // Search controller state: waiting for a request, or walking the ring.
    typedef enum logic {
        CVS_IDLE = 1'b0,
        CVS_SCAN = 1'b1
    } cvs_state_e;

endpackage

// File: rtl/cvs_frame_bits.sv
// Per-frame bookkeeping: one reference bit and one occupancy bit per frame.
// Assumes: at most one access, one fill, one sweep clear and one vacate per
// cycle. Access or fill setting a reference bit beats a sweep clear on the
// same frame. A fill beats a vacate on the same frame.
module cvs_frame_bits #(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = $clog2(NUM_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic [IDX_W-1:0]      acc_idx,
    input  logic                  fill_valid,
    input  logic [IDX_W-1:0]      fill_idx,
    input  logic                  clr_valid,
    input  logic [IDX_W-1:0]      clr_idx,
    input  logic                  vac_valid,
    input  logic [IDX_W-1:0]      vac_idx,
    output logic [NUM_FRAMES-1:0] ref_bits,
    output logic [NUM_FRAMES-1:0] occ_bits
);

    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);

        logic hit_acc;
        logic hit_fill;
        logic hit_clr;
        logic hit_vac;

        // Decode which requests address this frame.
        always_comb begin
            hit_acc  = acc_valid  && (acc_idx  == MY_IDX);
            hit_fill = fill_valid && (fill_idx == MY_IDX);
            hit_clr  = clr_valid  && (clr_idx  == MY_IDX);
            hit_vac  = vac_valid  && (vac_idx  == MY_IDX);
        end

        // Reference bit: a set request wins over the sweep clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ref_bits[i] <= 1'b0;
            end else if (hit_acc || hit_fill) begin
                ref_bits[i] <= 1'b1;
            end else if (hit_clr) begin
                ref_bits[i] <= 1'b0;
            end
        end

        // Occupancy bit: a fill wins over a vacate.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ_bits[i] <= 1'b0;
            end else if (hit_fill) begin
                occ_bits[i] <= 1'b1;
            end else if (hit_vac) begin
                occ_bits[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cvs_sweep_ctrl.sv
// Hand pointer and search controller. It inspects the frame under the hand
// once per cycle while scanning. It either takes that frame as the victim
// (empty, or reference bit clear) or asks for its reference bit to be cleared
// and moves on.
// Assumes: frame bits are registered elsewhere and seen one cycle after update.
// Requests seen during a scan are dropped.
module cvs_sweep_ctrl
    import cvs_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = $clog2(NUM_FRAMES),
    localparam int CNT_W = $clog2(NUM_FRAMES + 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  evict_req,
    input  logic [NUM_FRAMES-1:0] ref_bits,
    input  logic [NUM_FRAMES-1:0] occ_bits,
    output logic [IDX_W-1:0]      hand,
    output logic                  busy,
    output logic                  clr_valid,
    output logic [IDX_W-1:0]      clr_idx,
    output logic                  vac_valid,
    output logic [IDX_W-1:0]      vac_idx,
    output logic                  victim_valid,
    output logic [IDX_W-1:0]      victim_idx,
    output logic [CNT_W-1:0]      victim_probes
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

    cvs_state_e           state_q;
    logic [IDX_W-1:0]     hand_q;
    logic [IDX_W-1:0]     hand_nx;
    logic [CNT_W-1:0]     probes_q;
    logic                 take;
    logic                 pass;

    // Next hand position with wrap for any ring size.
    always_comb begin
        hand_nx = (hand_q == LAST_IDX) ? '0 : hand_q + 1'b1;
    end

    // Verdict on the frame under the hand during a scan.
    always_comb begin
        take = (state_q == CVS_SCAN) && (!occ_bits[hand_q] || !ref_bits[hand_q]);
        pass = (state_q == CVS_SCAN) && !take;
    end

    // Requests to the frame bookkeeping.
    always_comb begin
        clr_valid = pass;
        clr_idx   = hand_q;
        vac_valid = take;
        vac_idx   = hand_q;
        hand      = hand_q;
        busy      = (state_q == CVS_SCAN);
    end

    // Search sequencing, hand movement and registered result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= CVS_IDLE;
            hand_q        <= '0;
            probes_q      <= '0;
            victim_valid  <= 1'b0;
            victim_idx    <= '0;
            victim_probes <= '0;
        end else begin
            victim_valid <= 1'b0;
            case (state_q)
                CVS_IDLE: begin
                    if (evict_req) begin
                        state_q  <= CVS_SCAN;
                        probes_q <= CNT_W'(1);
                    end
                end
                default: begin
                    hand_q <= hand_nx;
                    if (take) begin
                        victim_valid  <= 1'b1;
                        victim_idx    <= hand_q;
                        victim_probes <= probes_q;
                        state_q       <= CVS_IDLE;
                    end else begin
                        probes_q <= probes_q + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/clock_victim_sel.sv
// Top of the clock second-chance victim selector. It joins the per-frame bit
// store with the sweep controller.
// Assumes: evict_req is a one-cycle pulse issued only when a victim is needed.
// Frame indices are below NUM_FRAMES.
module clock_victim_sel #(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = $clog2(NUM_FRAMES),
    localparam int CNT_W = $clog2(NUM_FRAMES + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             evict_req,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_idx,
    output logic [CNT_W-1:0] victim_probes
);

    logic [NUM_FRAMES-1:0] ref_w;
    logic [NUM_FRAMES-1:0] occ_w;
    logic [IDX_W-1:0]      hand_w;
    logic                  busy_w;
    logic                  clr_valid_w;
    logic [IDX_W-1:0]      clr_idx_w;
    logic                  vac_valid_w;
    logic [IDX_W-1:0]      vac_idx_w;

    cvs_frame_bits #(.NUM_FRAMES(NUM_FRAMES)) u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_idx    (acc_idx),
        .fill_valid (fill_valid),
        .fill_idx   (fill_idx),
        .clr_valid  (clr_valid_w),
        .clr_idx    (clr_idx_w),
        .vac_valid  (vac_valid_w),
        .vac_idx    (vac_idx_w),
        .ref_bits   (ref_w),
        .occ_bits   (occ_w)
    );

    cvs_sweep_ctrl #(.NUM_FRAMES(NUM_FRAMES)) u_sweep (
        .clk           (clk),
        .rst_n         (rst_n),
        .evict_req     (evict_req),
        .ref_bits      (ref_w),
        .occ_bits      (occ_w),
        .hand          (hand_w),
        .busy          (busy_w),
        .clr_valid     (clr_valid_w),
        .clr_idx       (clr_idx_w),
        .vac_valid     (vac_valid_w),
        .vac_idx       (vac_idx_w),
        .victim_valid  (victim_valid),
        .victim_idx    (victim_idx),
        .victim_probes (victim_probes)
    );

endmodule

// File: rtl/cvs_checker.sv
// Property checker for the clock victim selector, bound to the top module.
// Assumes: the hand, busy flag and frame bit vectors are visible in the top.
module cvs_checker #(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = $clog2(NUM_FRAMES),
    localparam int CNT_W = $clog2(NUM_FRAMES + 2)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  evict_req,
    input logic                  acc_valid,
    input logic [IDX_W-1:0]      acc_idx,
    input logic                  fill_valid,
    input logic [IDX_W-1:0]      fill_idx,
    input logic                  victim_valid,
    input logic [IDX_W-1:0]      victim_idx,
    input logic [CNT_W-1:0]      victim_probes,
    input logic [IDX_W-1:0]      hand,
    input logic                  busy,
    input logic [NUM_FRAMES-1:0] ref_bits,
    input logic [NUM_FRAMES-1:0] occ_bits
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);
    localparam logic [CNT_W-1:0] MAX_PRB  = CNT_W'(NUM_FRAMES + 1);

    logic [IDX_W-1:0] after_victim;

    // Expected hand position after a reported victim.
    always_comb begin
        after_victim = (victim_idx == LAST_IDX) ? '0 : victim_idx + 1'b1;
    end

    // R2
    scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && evict_req) |=> busy);

    // R3
    take_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (!occ_bits[hand] || !ref_bits[hand]))
        |=> (victim_valid && victim_idx == $past(hand)));

    // R4
    second_chance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && occ_bits[hand] && ref_bits[hand]
         && !(acc_valid && acc_idx == hand) && !(fill_valid && fill_idx == hand))
        |=> (!ref_bits[$past(hand)] && !victim_valid));

    // R6
    probe_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (victim_probes >= CNT_W'(1) && victim_probes <= MAX_PRB));

    // R7
    hand_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> (hand == after_victim));

    // R8
    fill_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (occ_bits[$past(fill_idx)] && ref_bits[$past(fill_idx)]));

    // R10
    access_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> ref_bits[$past(acc_idx)]);

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |=> !victim_valid);

endmodule

bind clock_victim_sel cvs_checker #(.NUM_FRAMES(NUM_FRAMES)) u_cvs_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .evict_req     (evict_req),
    .acc_valid     (acc_valid),
    .acc_idx       (acc_idx),
    .fill_valid    (fill_valid),
    .fill_idx      (fill_idx),
    .victim_valid  (victim_valid),
    .victim_idx    (victim_idx),
    .victim_probes (victim_probes),
    .hand          (hand_w),
    .busy          (busy_w),
    .ref_bits      (ref_w),
    .occ_bits      (occ_w)
);

// File: tb/tb_clock_victim_sel.sv
// Self-checking bench for the clock victim selector.
module tb_clock_victim_sel;

    localparam int NF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [2:0] acc_idx = '0;
    logic       fill_valid = 1'b0;
    logic [2:0] fill_idx = '0;
    logic       evict_req = 1'b0;
    logic       victim_valid;
    logic [2:0] victim_idx;
    logic [3:0] victim_probes;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit m_ref [NF];
    bit m_occ [NF];
    int m_hand;

    always #2 clk = ~clk;

    clock_victim_sel #(.NUM_FRAMES(NF)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_valid     (acc_valid),
        .acc_idx       (acc_idx),
        .fill_valid    (fill_valid),
        .fill_idx      (fill_idx),
        .evict_req     (evict_req),
        .victim_valid  (victim_valid),
        .victim_idx    (victim_idx),
        .victim_probes (victim_probes)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; acc_valid = 1'b0; fill_valid = 1'b0; evict_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NF; i++) begin m_ref[i] = 0; m_occ[i] = 0; end
        m_hand = 0;
    endtask

    task automatic do_fill(input int idx);
        @(negedge clk); fill_valid = 1'b1; fill_idx = 3'(idx);
        @(negedge clk); fill_valid = 1'b0;
        m_ref[idx] = 1; m_occ[idx] = 1;
    endtask

    task automatic do_access(input int idx);
        @(negedge clk); acc_valid = 1'b1; acc_idx = 3'(idx);
        @(negedge clk); acc_valid = 1'b0;
        m_ref[idx] = 1;
    endtask

    // Model prediction of a search from the current model state.
    task automatic predict(output int v, output int p);
        int h = m_hand;
        p = 0;
        forever begin
            p++;
            if (!m_occ[h] || !m_ref[h]) break;
            m_ref[h] = 0;
            h = (h + 1) % NF;
        end
        v = h;
        m_occ[h] = 0;
        m_hand = (h + 1) % NF;
    endtask

    // Wait for the victim strobe, counting negedges since the request edge.
    task automatic wait_victim(output int waited);
        waited = 1;
        while (!victim_valid && waited < 40) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic do_evict(input string req);
        int v, p, w;
        predict(v, p);
        @(negedge clk); evict_req = 1'b1;
        @(negedge clk); evict_req = 1'b0;
        wait_victim(w);
        chk(victim_valid == 1'b1, {req, " valid"}, int'(victim_valid), 1);
        chk(int'(victim_idx) == v, {req, " victim"}, int'(victim_idx), v);
        // R12 probe count
        chk(int'(victim_probes) == p, "R12 probes", int'(victim_probes), p);
        // R2 latency of one frame per cycle
        chk(w == p + 1, "R2 latency", w, p + 1);
        @(negedge clk);
        // R11 one-cycle strobe
        chk(victim_valid == 1'b0, "R11 pulse", int'(victim_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, w;
        void'($urandom(32'd2024));
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(victim_valid == 1'b0, "R1 valid low", int'(victim_valid), 0);
        do_evict("R1 first search");

        // R5 empty frame with set reference bit taken at once
        do_reset();
        for (int i = 1; i < NF; i++) do_fill(i);
        do_access(0);
        do_evict("R5 empty frame");

        // R6 all set: full sweep, victim is the start frame, probes NF+1
        do_reset();
        for (int i = 0; i < NF; i++) do_fill(i);
        do_access(0);
        do_evict("R6 full sweep");
        chk(int'(victim_probes) == NF + 1, "R6 max probes", int'(victim_probes), NF + 1);
        chk(int'(victim_idx) == 0, "R4 second chance", int'(victim_idx), 0);

        // R7 and R8: refill behind the hand, walk the ring past the wrap
        for (int k = 0; k < 10; k++) begin
            do_fill((m_hand + NF - 1) % NF);
            if (k % 3 == 0) do_access((m_hand + 2) % NF);
            do_evict("R7 wrap walk");
        end

        // R3 and R9: only one frame with a clear bit among set frames
        do_reset();
        for (int i = 0; i < NF; i++) do_fill(i);
        do_evict("R3 setup");
        do_fill(0);
        for (int i = 1; i < NF; i++) if (i != 5) do_access(i);
        do_evict("R3 clear bit chosen");
        chk(int'(victim_idx) == 5, "R9 access kept frames", int'(victim_idx), 5);

        // R10 access collides with sweep clear on frame 3
        do_reset();
        for (int i = 0; i < NF; i++) do_fill(i);
        @(negedge clk); evict_req = 1'b1;
        @(negedge clk); evict_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); acc_valid = 1'b1; acc_idx = 3'd3;
        @(negedge clk); acc_valid = 1'b0;
        w = 5;
        while (!victim_valid && w < 40) begin @(negedge clk); w++; end
        chk(int'(victim_idx) == 0 && int'(victim_probes) == 9, "R10 sweep",
            int'(victim_idx), 0);
        for (int i = 0; i < NF; i++) m_ref[i] = 0;
        m_ref[3] = 1; m_occ[0] = 0; m_hand = 1;
        do_fill(0);
        do_access(1);
        do_access(2);
        do_evict("R10 set wins");
        chk(int'(victim_idx) == 4, "R10 frame 3 spared", int'(victim_idx), 4);

        // R11 request during a scan is ignored
        do_reset();
        for (int i = 0; i < NF; i++) do_fill(i);
        predict(v, w);
        @(negedge clk); evict_req = 1'b1;
        @(negedge clk); evict_req = 1'b0;
        @(negedge clk); evict_req = 1'b1;
        @(negedge clk); evict_req = 1'b0;
        w = 3;
        while (!victim_valid && w < 40) begin @(negedge clk); w++; end
        chk(int'(victim_idx) == v, "R11 victim", int'(victim_idx), v);
        begin
            int extra = 0;
            repeat (14) begin @(negedge clk); if (victim_valid) extra++; end
            chk(extra == 0, "R11 extra request ignored", extra, 0);
        end

        // Random mix of accesses, fills and searches
        do_reset();
        for (int n = 0; n < 300; n++) begin
            int op = int'($urandom % 4);
            int ix = int'($urandom % NF);
            case (op)
                0: do_access(ix);
                1: do_fill(ix);
                default: do_evict("R3 random");
            endcase
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule